// File: doc/BRIEF.md
# Fundamental Reset Source Controller

This block collects every condition that may force a fundamental reset of a PCIe switch-style device and turns them into one internal reset, `core_rst`. The conditions are: power becoming good (a cold reset); the external PCIe reset pin asserting while power is already good; one-cycle software reset strobes from the switch control register and from the control registers on the internal and external sides of the bridge; and the bridge reset pin. The bridge strobes only count in non-transparent mode. The bridge pin only counts in non-transparent mode with at least one of the two propagate bits set.

After any trigger, the block holds the reset for a fixed number of cycles. It then pulses a start request to the serial-EEPROM loader and waits for its done signal. If done does not arrive within the loader budget (200 ms, scaled by parameters), the block sets a sticky timeout flag and releases the reset anyway. A status flag records whether the last reset was cold or warm. While the reset is active, a per-GPIO mask forces every GPIO back to input direction, so downstream reset outputs that share those pins float.

The pins pass through two-flop synchronizers. `core_rst` asserts at once from the raw pins and releases only through the registered sequence.

Top module: `fund_rst_ctrl`

## Requirements
- R1: While `pwr_good_n` is high, `core_rst` is high with no clock delay. A falling `pwr_good_n` starts a cold reset: 3 cycles after the change, `cold_rst` reads 1 and the hold phase has begun.
- R2: If `perst_n` falls while power is good, `core_rst` goes high with no clock delay and a warm reset begins 3 cycles later. The hold phase stays at its start for as long as `perst_n` is low.
- R3: A one-cycle pulse on `sw_rst_wr` starts a warm reset, and `core_rst` is high in the cycle after the pulse.
- R4: A pulse on `brg_int_rst_wr` or `brg_ext_rst_wr` starts a warm reset only while `nt_mode` is 1. With `nt_mode` at 0, `core_rst` stays low.
- R5: A low `brg_rst_n` asserts `core_rst` and starts a warm reset only when `nt_mode` is 1 and `pefr_int` or `pefr_ext` is 1. Otherwise it has no effect.
- R6: The hold phase lasts exactly `RST_CYCLES` cycles once every held pin has released. `ee_start` is then high for exactly one cycle, which is the first cycle of the load phase.
- R7: `ee_done` high during the load phase drops `core_rst` in the next cycle.
- R8: If `ee_done` has not come after `INIT_BUDGET_MS*TICKS_PER_MS` load cycles, `core_rst` drops and `init_timeout` goes to 1. The flag is cleared only by `rst` or by loss of power.
- R9: A warm trigger during the hold or load phase restarts the hold phase from its first cycle.
- R10: `gpio_force_in` is all ones while `core_rst` is high and all zeros otherwise.
- R11: `cold_rst` is set only by power-up and is cleared by any later warm reset.
- R12: Synchronous `rst` clears `cold_rst`, `init_timeout` and `ee_start` and holds `core_rst` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| pwr_good_n | input | 1 | Power good, active low, asynchronous |
| perst_n | input | 1 | External PCIe reset pin, active low, asynchronous |
| brg_rst_n | input | 1 | Bridge reset pin, active low, asynchronous |
| sw_rst_wr | input | 1 | Switch control reset bit write strobe |
| brg_int_rst_wr | input | 1 | Internal-side bridge control reset bit write strobe |
| brg_ext_rst_wr | input | 1 | External-side bridge control reset bit write strobe |
| nt_mode | input | 1 | 1 = non-transparent operation |
| pefr_int | input | 1 | Propagate bridge reset, internal side |
| pefr_ext | input | 1 | Propagate bridge reset, external side |
| ee_done | input | 1 | EEPROM loader finished |
| core_rst | output | 1 | Internal fundamental reset, active high |
| ee_start | output | 1 | One-cycle loader start request |
| cold_rst | output | 1 | 1 = the last reset was a power-up reset |
| init_timeout | output | 1 | Sticky loader-timeout flag |
| gpio_force_in | output | GPIO_W | Per-GPIO force-to-input mask |

## Verification
Each result has its own latency. A pin change moves the registered state three cycles later: two synchronizer stages and then the sequencer. A software strobe shows up one cycle later. The raw-pin assertion of `core_rst` appears within the same cycle, and the bench checks it one nanosecond after driving the pin. Load begins `RST_CYCLES` cycles after the hold starts, or `RST_CYCLES+2` cycles after a held pin is released, and the release comes one cycle after `ee_done` or exactly budget cycles into the load. The bench drives and samples only on falling edges, steps by those counts, and checks the cycle before each transition as well as the transition cycle itself.

// File: rtl/frc_pkg.sv
package frc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_INIT = 2'd2,
        ST_RUN  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic sw_wr;
        logic brg_int_wr;
        logic brg_ext_wr;
        logic nt_mode;
        logic pefr_int;
        logic pefr_ext;
    } sw_ctl_t;

    typedef struct packed {
        logic warm_evt;
        logic hold;
    } rst_req_t;

    function automatic logic brg_pin_enabled(logic nt, logic pi, logic pe);
        return nt & (pi | pe);
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/frc_sync.sv
module frc_sync #(
    parameter int unsigned   W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/frc_src_gate.sv
module frc_src_gate
    import frc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwr_ok,
    input  logic     perst_act,
    input  logic     brg_act,
    input  sw_ctl_t  ctl,
    output rst_req_t req
);
    logic perst_d;
    logic brg_d;
    logic brg_q;
    logic perst_evt;
    logic brg_evt;
    logic sw_evt;

    assign brg_q = brg_act & brg_pin_enabled(ctl.nt_mode, ctl.pefr_int, ctl.pefr_ext);

    always_ff @(posedge clk) begin
        if (rst) begin
            perst_d <= 1'b1;
            brg_d   <= 1'b0;
        end else begin
            perst_d <= perst_act;
            brg_d   <= brg_q;
        end
    end

    assign perst_evt = perst_act & ~perst_d;
    assign brg_evt   = brg_q & ~brg_d;
    assign sw_evt    = ctl.sw_wr | (ctl.nt_mode & (ctl.brg_int_wr | ctl.brg_ext_wr));

    assign req.warm_evt = pwr_ok & (perst_evt | brg_evt | sw_evt);
    assign req.hold     = pwr_ok & (perst_act | brg_q);

    // R4: bridge register writes outside non-transparent mode start nothing
    p_brg_wr_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.nt_mode && !ctl.sw_wr && !perst_evt && !brg_evt) |-> !req.warm_evt);

    // R5: a bridge pin edge only counts when the pin is enabled
    p_brg_pin_gated_r5: assert property (@(posedge clk) disable iff (rst)
        (brg_evt && pwr_ok) |-> (ctl.nt_mode && (ctl.pefr_int || ctl.pefr_ext) && req.warm_evt));
endmodule

// File: rtl/frc_seq.sv
module frc_seq
    import frc_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 16,
    parameter int unsigned INIT_LIMIT = 200
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pwr_ok,
    input  rst_req_t req,
    input  logic     ee_done,
    output logic     busy,
    output logic     ee_start,
    output logic     cold,
    output logic     tmo
);
    localparam int unsigned CNT_MAX   = max2(RST_CYCLES, INIT_LIMIT);
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);
    localparam int unsigned HOLD_LAST = RST_CYCLES - 1;
    localparam int unsigned INIT_LAST = INIT_LIMIT - 1;

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             cold_q;
    logic             tmo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cold_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else if (!pwr_ok) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tmo_q   <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
            cold_q  <= 1'b1;
        end else if (req.warm_evt) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
            cold_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_HOLD: begin
                    if (req.hold) begin
                        cnt_q <= '0;
                    end else if (cnt_q == CNT_W'(HOLD_LAST)) begin
                        state_q <= ST_INIT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_INIT: begin
                    if (ee_done) begin
                        state_q <= ST_RUN;
                    end else if (cnt_q == CNT_W'(INIT_LAST)) begin
                        state_q <= ST_RUN;
                        tmo_q   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q != ST_RUN);
    assign ee_start = (state_q == ST_INIT) && (cnt_q == '0);
    assign cold     = cold_q;
    assign tmo      = tmo_q;

    // R6: load begins only after the full hold count
    p_hold_len_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_INIT && $past(state_q) == ST_HOLD) |-> $past(cnt_q) == CNT_W'(HOLD_LAST));

    // R6: start request lasts one cycle
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        ee_start |=> !ee_start);

    // R7: the run state is entered only from load, on done or timeout
    p_run_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |->
            ($past(state_q) == ST_INIT && ($past(ee_done) || tmo_q)));

    // R11: a warm trigger clears the cold status
    p_warm_clears_cold_r11: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && state_q != ST_IDLE && req.warm_evt) |=> !cold_q);

    // R8: the timeout flag only drops on power loss
    p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(tmo_q) |-> !$past(pwr_ok));
endmodule

// File: rtl/fund_rst_ctrl.sv
module fund_rst_ctrl
    import frc_pkg::*;
#(
    parameter int unsigned RST_CYCLES     = 16,
    parameter int unsigned TICKS_PER_MS   = 1000,
    parameter int unsigned INIT_BUDGET_MS = 200,
    parameter int unsigned GPIO_W         = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good_n,
    input  logic              perst_n,
    input  logic              brg_rst_n,
    input  logic              sw_rst_wr,
    input  logic              brg_int_rst_wr,
    input  logic              brg_ext_rst_wr,
    input  logic              nt_mode,
    input  logic              pefr_int,
    input  logic              pefr_ext,
    input  logic              ee_done,
    output logic              core_rst,
    output logic              ee_start,
    output logic              cold_rst,
    output logic              init_timeout,
    output logic [GPIO_W-1:0] gpio_force_in
);
    localparam int unsigned INIT_LIMIT = INIT_BUDGET_MS * TICKS_PER_MS;
    localparam int unsigned N_PINS     = 3;

    logic [N_PINS-1:0] pins_raw;
    logic [N_PINS-1:0] pins_sync;
    sw_ctl_t           ctl;
    rst_req_t          req;
    logic              busy;
    logic              raw_assert;

    assign pins_raw = {pwr_good_n, perst_n, brg_rst_n};

    frc_sync #(.W(N_PINS), .RST_VAL(3'b101)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_sync)
    );

    assign ctl = '{sw_wr:      sw_rst_wr,
                   brg_int_wr: brg_int_rst_wr,
                   brg_ext_wr: brg_ext_rst_wr,
                   nt_mode:    nt_mode,
                   pefr_int:   pefr_int,
                   pefr_ext:   pefr_ext};

    frc_src_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .pwr_ok    (~pins_sync[2]),
        .perst_act (~pins_sync[1]),
        .brg_act   (~pins_sync[0]),
        .ctl       (ctl),
        .req       (req)
    );

    frc_seq #(.RST_CYCLES(RST_CYCLES), .INIT_LIMIT(INIT_LIMIT)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pwr_ok   (~pins_sync[2]),
        .req      (req),
        .ee_done  (ee_done),
        .busy     (busy),
        .ee_start (ee_start),
        .cold     (cold_rst),
        .tmo      (init_timeout)
    );

    assign raw_assert = pwr_good_n | ~perst_n |
                        (~brg_rst_n & brg_pin_enabled(nt_mode, pefr_int, pefr_ext));

    assign core_rst      = busy | raw_assert;
    assign gpio_force_in = {GPIO_W{core_rst}};
endmodule

// File: tb/fund_rst_ctrl_tb_top.sv
`timescale 1ns/1ps
module fund_rst_ctrl_tb_top;
    localparam int RC  = 4;
    localparam int TPM = 2;
    localparam int BMS = 10;
    localparam int LIM = TPM * BMS;
    localparam int GW  = 4;

    logic clk = 1'b0;
    logic rst, pwr_good_n, perst_n, brg_rst_n;
    logic sw_rst_wr, brg_int_rst_wr, brg_ext_rst_wr;
    logic nt_mode, pefr_int, pefr_ext, ee_done;
    logic core_rst, ee_start, cold_rst, init_timeout;
    logic [GW-1:0] gpio_force_in;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    fund_rst_ctrl #(.RST_CYCLES(RC), .TICKS_PER_MS(TPM), .INIT_BUDGET_MS(BMS), .GPIO_W(GW)) dut_i (
        .clk(clk), .rst(rst), .pwr_good_n(pwr_good_n), .perst_n(perst_n), .brg_rst_n(brg_rst_n),
        .sw_rst_wr(sw_rst_wr), .brg_int_rst_wr(brg_int_rst_wr), .brg_ext_rst_wr(brg_ext_rst_wr),
        .nt_mode(nt_mode), .pefr_int(pefr_int), .pefr_ext(pefr_ext), .ee_done(ee_done),
        .core_rst(core_rst), .ee_start(ee_start), .cold_rst(cold_rst),
        .init_timeout(init_timeout), .gpio_force_in(gpio_force_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_fires(int src, logic nt, logic pi, logic pe);
        case (src)
            0: return 1'b1;
            1, 2: return nt;
            3: return nt & (pi | pe);
            default: return 1'b1;
        endcase
    endfunction

    task automatic finish_init(input string tag);
        for (int i = 0; i < 100 && !ee_start; i++) step(1);
        chk({tag, " R6 start seen"}, ee_start, 1);
        ee_done = 1'b1;
        step(1);
        ee_done = 1'b0;
        chk({tag, " R7 release"}, core_rst, 0);
        chk({tag, " R10 mask off"}, gpio_force_in, '0);
    endtask

    task automatic pulse_sw();
        sw_rst_wr = 1'b1; step(1); sw_rst_wr = 1'b0;
    endtask

    initial begin
        rst = 1; pwr_good_n = 1; perst_n = 0; brg_rst_n = 1;
        sw_rst_wr = 0; brg_int_rst_wr = 0; brg_ext_rst_wr = 0;
        nt_mode = 0; pefr_int = 0; pefr_ext = 0; ee_done = 0;
        step(3);
        chk("R12 core_rst in reset", core_rst, 1);
        chk("R12 cold in reset", cold_rst, 0);
        chk("R12 tmo in reset", init_timeout, 0);
        chk("R12 start in reset", ee_start, 0);
        chk("R10 mask in reset", gpio_force_in, {GW{1'b1}});
        rst = 0;
        step(2);
        chk("R1 power bad holds reset", core_rst, 1);

        // R1 cold power-up with PCIe reset held
        pwr_good_n = 0;
        step(2); chk("R1 cold not yet", cold_rst, 0);
        step(1); chk("R1 cold set", cold_rst, 1);
        step(2);
        perst_n = 1;
        step(RC + 1);
        chk("R6 no start before hold ends", ee_start, 0);
        chk("R6 still in reset", core_rst, 1);
        step(1);
        chk("R6 start after hold", ee_start, 1);
        ee_done = 1; step(1); ee_done = 0;
        chk("R7 release after done", core_rst, 0);
        chk("R6 start one cycle", ee_start, 0);
        chk("R11 cold kept", cold_rst, 1);

        // R2 warm reset through PCIe pin
        perst_n = 0; #1;
        chk("R2 immediate assert", core_rst, 1);
        step(2); chk("R11 cold before sync", cold_rst, 1);
        step(1); chk("R11 cold cleared by warm", cold_rst, 0);
        step(3);
        perst_n = 1;
        step(RC + 1); chk("R2 hold while pin low", ee_start, 0);
        step(1); chk("R2 start after release", ee_start, 1);
        finish_init("R2");

        // R4 bridge writes in transparent mode
        nt_mode = 0;
        brg_int_rst_wr = 1; step(1); brg_int_rst_wr = 0;
        chk("R4 int write ignored", core_rst, 0);
        brg_ext_rst_wr = 1; step(1); brg_ext_rst_wr = 0;
        chk("R4 ext write ignored", core_rst, 0);
        step(2); chk("R4 still running", core_rst, 0);

        // R4 bridge write in non-transparent mode, R6 hold length
        nt_mode = 1;
        brg_ext_rst_wr = 1; step(1); brg_ext_rst_wr = 0;
        chk("R4 ext write fires", core_rst, 1);
        step(RC - 1); chk("R6 no start early", ee_start, 0);
        step(1); chk("R6 start on time", ee_start, 1);
        finish_init("R4");

        // R9 restart during load
        pulse_sw();
        chk("R3 switch write fires", core_rst, 1);
        step(RC); chk("R9 load reached", ee_start, 1);
        step(3);
        pulse_sw();
        chk("R9 back to hold", ee_start, 0);
        step(RC - 1); chk("R9 hold restarted", ee_start, 0);
        step(1); chk("R9 start again", ee_start, 1);
        finish_init("R9");

        // R5 bridge pin gating
        nt_mode = 1; pefr_int = 0; pefr_ext = 0;
        brg_rst_n = 0; step(1);
        chk("R5 pin ignored without propagate", core_rst, 0);
        step(3); chk("R5 still ignored", core_rst, 0);
        brg_rst_n = 1; step(3);
        chk("R5 ignored after release", core_rst, 0);
        pefr_int = 1;
        brg_rst_n = 0; #1;
        chk("R5 pin asserts", core_rst, 1);
        step(4);
        brg_rst_n = 1;
        step(RC + 1); chk("R5 hold while pin low", ee_start, 0);
        step(1); chk("R5 start after release", ee_start, 1);
        finish_init("R5");
        pefr_int = 0; pefr_ext = 1; nt_mode = 0;
        brg_rst_n = 0; step(1);
        chk("R5 ignored in transparent mode", core_rst, 0);
        brg_rst_n = 1; step(3);
        pefr_ext = 0;

        // R8 timeout
        pulse_sw();
        step(RC); chk("R8 load entered", ee_start, 1);
        step(LIM - 1);
        chk("R8 still loading", core_rst, 1);
        chk("R8 no timeout yet", init_timeout, 0);
        step(1);
        chk("R8 released on timeout", core_rst, 0);
        chk("R8 timeout set", init_timeout, 1);
        pulse_sw();
        finish_init("R8");
        chk("R8 timeout sticky", init_timeout, 1);

        // R1 power loss and second power-up
        pwr_good_n = 1; #1;
        chk("R1 power loss asserts", core_rst, 1);
        step(3); chk("R8 timeout cleared by power loss", init_timeout, 0);
        pwr_good_n = 0;
        step(3); chk("R1 cold after re-power", cold_rst, 1);
        finish_init("R1");

        // random mix of sources and gating
        begin
            int unsigned seed_v;
            seed_v = $urandom(32'h5EED_0017);
            for (int it = 0; it < 40; it++) begin
                int  src;
                logic nt, pi, pe, ex;
                src = int'($urandom % 5);
                nt = 1'($urandom); pi = 1'($urandom); pe = 1'($urandom);
                nt_mode = nt; pefr_int = pi; pefr_ext = pe;
                step(2);
                ex = exp_fires(src, nt, pi, pe);
                case (src)
                    0: begin sw_rst_wr = 1; step(1); sw_rst_wr = 0;
                             chk("R3 random switch write", core_rst, ex); end
                    1: begin brg_int_rst_wr = 1; step(1); brg_int_rst_wr = 0;
                             chk("R4 random int write", core_rst, ex); end
                    2: begin brg_ext_rst_wr = 1; step(1); brg_ext_rst_wr = 0;
                             chk("R4 random ext write", core_rst, ex); end
                    3: begin brg_rst_n = 0; #1;
                             chk("R5 random bridge pin", core_rst, ex);
                             step(1); brg_rst_n = 1; end
                    default: begin perst_n = 0; #1;
                             chk("R2 random pcie pin", core_rst, ex);
                             step(1); perst_n = 1; end
                endcase
                if (ex) begin
                    finish_init("R3 random");
                    chk("R11 random warm clears cold", cold_rst, 0);
                end else begin
                    step(4);
                    chk("R4 random no effect", core_rst, 0);
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule